// File: doc/BRIEF.md
# Register-mapped EDID read controller

This block sits behind a small register port and behaves like the front end of an I2C master whose only target is a display's EDID memory. No bus pins exist: the EDID contents arrive as a flat input vector, and a presence and a DP-type flag per display port tell the block whether a readable monitor is attached. Software selects a port, writes a command word that carries the byte count, a start index, the target address and a cycle type, and then drains the bytes through repeated reads of a 32-bit data register. Each data read returns up to four bytes.

The block tracks the bus phase (idle, data, wait) from register traffic alone. The phase moves forward when commands are written and when data-register reads use up the requested byte count. It does not depend on bus timing. A status register reports ready, error, active and wait conditions. It also holds a semaphore bit that software takes by reading the register and gives back by writing it.

Registers are chosen by `addr`: 0 pin select, 1 command, 2 status, 3 data. Only one access is taken per cycle, and a write wins over a read. Read data appears on `rdata` in the cycle after the access and stays there until the next read.

Top module: `edid_reg_ctrl`

## Requirements
- R1: After reset, status reads 0x0000_0C00: ready (bit 11) and error (bit 10) set, with in-use (bit 15), wait (bit 14) and active (bit 9) clear. Ready reads 1 at all times.
- R2: A status read returns the value held before the read and then sets in-use (bit 15). A status write with bit 15 = 1 clears in-use. Writes have no effect on any other status bit.
- R3: A pin-select write stores wdata[2:0], which reads back zero-extended. It clears the EDID state (selection, availability, pointer, byte count). A value s in 1..NPORT names port s-1, goes to idle and clears active. If a display is present on that port and is not DP, EDID becomes available and error clears; otherwise error sets. Values 0 and above NPORT only clear the EDID state.
- R4: Command fields: bit 0 read direction, bits 7:1 target address, bits 15:8 index, bits 24:16 byte count, bits 27:25 cycle type, bit 30 software-ready, bit 31 clear-interrupt. Address 0x50 selects the EDID. Any other address leaves the selection unchanged.
- R5: The command register reads back the last accepted command word with bit 30 forced to 0.
- R6: Command bit 26 (the index flag) loads the read pointer from the index field.
- R7: Cycle type 0 changes no phase. Types 1, 3, 5 and 7 enter the data phase and set active. Type 4 (stop) applies only when the stored cycle type is nonzero: it clears the EDID state, goes to idle and clears active.
- R8: A data read while stored bit 0 = 1 and remaining = count - pointer > 0 fetches min(remaining, 4) bytes. The first byte goes in bits 7:0. Byte lanes that are not fetched keep their old value. In every other case the old data value is returned unchanged.
- R9: A data read with remaining <= 4 ends the transfer. Stored types 5 and 7 go to idle. Any other type goes to the wait phase (status bit 14). The EDID state is then cleared.
- R10: A byte fetched with no selection, with EDID unavailable, or at a pointer >= 128 reads 0 and does not advance the pointer.
- R11: When stored bit 31 = 1, a command write with bit 31 = 1 is ignored entirely. A command write with bit 31 = 0 clears stored bit 31 and resets the status to ready plus error when EDID is unavailable (in-use and active clear, idle). It leaves the rest of the command word untouched.
- R12: Data-register writes have no effect. The result of every read appears on rdata one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 pin, 1 command, 2 status, 3 data |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read |
| disp_present | input | NPORT | Display attached, one bit per port |
| disp_is_dp | input | NPORT | Attached display is DP type, one bit per port |
| edid_bytes | input | EDID_BYTES*8 | EDID contents, byte k in bits 8k+7:8k |

## Verification
The data path is tried with a plain transfer from index 0 whose last read is partial. It is also tried with an indexed transfer near the top of the memory and a transfer that runs past byte 127. Together these separate lane packing, keeping of unfetched lanes, the index load and the zero fill at the end of memory. Reads under a foreign target address, on a DP port and with the read direction clear check that a fetch yields zero only when the bytes are truly unreachable, and that the old word comes back otherwise. Command sequences with stop after no-cycle and stop after a data cycle, plus the clear-interrupt protocol, show which writes are allowed to change the phase, active and error state. Status reads and writes show which bits software can and cannot alter.

// File: rtl/edid_ctrl_pkg.sv
package edid_ctrl_pkg;

    localparam int PTR_W = 8;
    localparam int CNT_W = 9;

    localparam logic [1:0] REG_PIN  = 2'd0;
    localparam logic [1:0] REG_CMD  = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_DATA = 2'd3;

    localparam int ST_INUSE  = 15;
    localparam int ST_WAIT   = 14;
    localparam int ST_HWRDY  = 11;
    localparam int ST_ERR    = 10;
    localparam int ST_ACTIVE = 9;

    localparam int CMD_CLRINT = 31;
    localparam int CMD_SWRDY  = 30;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_WAIT = 2'd2
    } phase_t;

    typedef enum logic [2:0] {
        CY_NONE    = 3'd0,
        CY_PLAIN   = 3'd1,
        CY_RSV2    = 3'd2,
        CY_IDX     = 3'd3,
        CY_STOP    = 3'd4,
        CY_PLAIN_S = 3'd5,
        CY_RSV6    = 3'd6,
        CY_IDX_S   = 3'd7
    } cycle_t;

    typedef struct packed {
        logic              clr_int;
        logic              sw_rdy;
        cycle_t            cyc;
        logic [CNT_W-1:0]  total;
        logic [PTR_W-1:0]  index;
        logic [6:0]        taddr;
        logic              rd_dir;
    } cmd_t;

    typedef struct packed {
        logic              sel;
        logic              avail;
        logic [PTR_W-1:0]  ptr;
        logic [CNT_W-1:0]  total;
        phase_t            phase;
        logic              active;
        logic              err;
        logic              inuse;
        logic [2:0]        pinsel;
        logic [31:0]       cmd;
        logic [31:0]       data;
    } ctrl_st_t;

    function automatic cmd_t cmd_unpack(logic [31:0] w);
        cmd_t c;
        c.clr_int = w[31];
        c.sw_rdy  = w[30];
        c.cyc     = cycle_t'(w[27:25]);
        c.total   = w[24:16];
        c.index   = w[15:8];
        c.taddr   = w[7:1];
        c.rd_dir  = w[0];
        return c;
    endfunction

    function automatic ctrl_st_t st_clear_edid(ctrl_st_t s);
        ctrl_st_t r;
        r       = s;
        r.sel   = 1'b0;
        r.avail = 1'b0;
        r.ptr   = '0;
        r.total = '0;
        return r;
    endfunction

    function automatic ctrl_st_t st_reset_value();
        ctrl_st_t r;
        r       = '0;
        r.phase = PH_IDLE;
        r.err   = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] status_word(ctrl_st_t s);
        logic [31:0] w;
        w            = '0;
        w[ST_INUSE]  = s.inuse;
        w[ST_WAIT]   = (s.phase == PH_WAIT);
        w[ST_HWRDY]  = 1'b1;
        w[ST_ERR]    = s.err;
        w[ST_ACTIVE] = s.active;
        return w;
    endfunction

endpackage

// File: rtl/edid_cmd_dec.sv
module edid_cmd_dec
    import edid_ctrl_pkg::*;
#(
    parameter logic [6:0] TARGET = 7'h50
) (
    input  logic [31:0] word,
    output cmd_t        fld,
    output logic        hit,
    output logic        data_cyc,
    output logic        stop_cyc,
    output logic        idx_load
);
    always_comb begin
        fld      = cmd_unpack(word);
        hit      = (fld.taddr == TARGET);
        data_cyc = fld.cyc[0];
        stop_cyc = (fld.cyc == CY_STOP);
        idx_load = fld.cyc[1];
    end
endmodule

// File: rtl/edid_pin_map.sv
module edid_pin_map #(
    parameter int NPORT = 4
) (
    input  logic [2:0]       sel,
    input  logic [NPORT-1:0] present,
    input  logic [NPORT-1:0] is_dp,
    output logic             port_ok,
    output logic             sink_ok
);
    always_comb begin
        port_ok = (sel != 3'd0) && (int'(sel) <= NPORT);
        sink_ok = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if (int'(sel) == p + 1) begin
                sink_ok = present[p] & ~is_dp[p];
            end
        end
    end
endmodule

// File: rtl/edid_word_fetch.sv
module edid_word_fetch #(
    parameter int EDID_BYTES = 128
) (
    input  logic [7:0] mem [EDID_BYTES],
    input  logic [7:0] ptr,
    input  logic [2:0] count,
    input  logic       good,
    input  logic [31:0] old_word,
    output logic [31:0] new_word,
    output logic [2:0]  adv
);
    localparam int AW = (EDID_BYTES > 1) ? $clog2(EDID_BYTES) : 1;
    localparam logic [8:0] LIMIT = 9'(EDID_BYTES);

    logic [3:0] lane_hit;

    for (genvar i = 0; i < 4; i++) begin : g_lane
        logic [8:0]    pos;
        logic          take;
        logic          valid;
        logic [AW-1:0] idx;
        assign pos   = {1'b0, ptr} + 9'(i);
        assign take  = (3'(i) < count);
        assign valid = good && (pos < LIMIT);
        assign idx   = valid ? pos[AW-1:0] : '0;
        assign lane_hit[i] = take & valid;
        assign new_word[8*i +: 8] = take ? (valid ? mem[idx] : 8'h00)
                                         : old_word[8*i +: 8];
    end

    always_comb begin
        adv = '0;
        for (int i = 0; i < 4; i++) begin
            adv = adv + {2'b00, lane_hit[i]};
        end
    end
endmodule

// File: rtl/edid_reg_ctrl.sv
module edid_reg_ctrl
    import edid_ctrl_pkg::*;
#(
    parameter int         NPORT      = 4,
    parameter int         EDID_BYTES = 128,
    parameter logic [6:0] EDID_ADDR  = 7'h50
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [1:0]              addr,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    input  logic [NPORT-1:0]        disp_present,
    input  logic [NPORT-1:0]        disp_is_dp,
    input  logic [EDID_BYTES*8-1:0] edid_bytes
);
    ctrl_st_t    st_q, st_d;
    logic [31:0] rdata_q, rdata_d;

    logic [7:0] mem_a [EDID_BYTES];
    for (genvar k = 0; k < EDID_BYTES; k++) begin : g_mem
        assign mem_a[k] = edid_bytes[8*k +: 8];
    end

    // command decode of the incoming write word
    cmd_t wr_cmd;
    logic cmd_hit, cmd_data, cmd_stop, cmd_idx;
    edid_cmd_dec #(.TARGET(EDID_ADDR)) u_dec (
        .word     (wdata),
        .fld      (wr_cmd),
        .hit      (cmd_hit),
        .data_cyc (cmd_data),
        .stop_cyc (cmd_stop),
        .idx_load (cmd_idx)
    );

    // port lookup for pin-select writes
    logic port_ok, sink_ok;
    edid_pin_map #(.NPORT(NPORT)) u_pin (
        .sel     (wdata[2:0]),
        .present (disp_present),
        .is_dp   (disp_is_dp),
        .port_ok (port_ok),
        .sink_ok (sink_ok)
    );

    // remaining-byte arithmetic for data reads
    logic [9:0] remain;
    logic       rem_pos, rem_last;
    logic [2:0] fetch_cnt;
    assign remain    = {1'b0, st_q.total} - {2'b00, st_q.ptr};
    assign rem_pos   = !remain[9] && (remain != 10'd0);
    assign rem_last  = rem_pos && (remain <= 10'd4);
    assign fetch_cnt = (rem_pos && remain >= 10'd4) ? 3'd4 : remain[2:0];

    logic [31:0] fetched;
    logic [2:0]  adv;
    edid_word_fetch #(.EDID_BYTES(EDID_BYTES)) u_fetch (
        .mem      (mem_a),
        .ptr      (st_q.ptr),
        .count    (fetch_cnt),
        .good     (st_q.sel && st_q.avail),
        .old_word (st_q.data),
        .new_word (fetched),
        .adv      (adv)
    );

    cycle_t stored_cyc;
    assign stored_cyc = cycle_t'(st_q.cmd[27:25]);

    always_comb begin
        st_d    = st_q;
        rdata_d = rdata_q;
        if (wr_en) begin
            unique case (addr)
                REG_PIN: begin
                    st_d        = st_clear_edid(st_q);
                    st_d.pinsel = wdata[2:0];
                    if (port_ok) begin
                        st_d.phase  = PH_IDLE;
                        st_d.active = 1'b0;
                        if (sink_ok) begin
                            st_d.avail = 1'b1;
                            st_d.err   = 1'b0;
                        end else begin
                            st_d.err = 1'b1;
                        end
                    end
                end
                REG_CMD: begin
                    if (st_q.cmd[CMD_CLRINT]) begin
                        if (!wr_cmd.clr_int) begin
                            st_d.cmd[CMD_CLRINT] = 1'b0;
                            st_d.inuse  = 1'b0;
                            st_d.active = 1'b0;
                            st_d.err    = !st_q.avail;
                            st_d.phase  = PH_IDLE;
                        end
                    end else begin
                        st_d.total = wr_cmd.total;
                        if (cmd_hit) st_d.sel = 1'b1;
                        if (cmd_idx) st_d.ptr = wr_cmd.index;
                        if (cmd_stop) begin
                            if (stored_cyc != CY_NONE) begin
                                st_d        = st_clear_edid(st_d);
                                st_d.phase  = PH_IDLE;
                                st_d.active = 1'b0;
                            end
                        end else if (cmd_data) begin
                            st_d.phase  = PH_DATA;
                            st_d.active = 1'b1;
                        end
                        st_d.cmd = wdata;
                        st_d.cmd[CMD_SWRDY] = 1'b0;
                    end
                end
                REG_STAT: begin
                    if (wdata[ST_INUSE]) st_d.inuse = 1'b0;
                end
                default: ;
            endcase
        end else if (rd_en) begin
            unique case (addr)
                REG_PIN:  rdata_d = {29'b0, st_q.pinsel};
                REG_CMD:  rdata_d = st_q.cmd;
                REG_STAT: begin
                    rdata_d    = status_word(st_q);
                    st_d.inuse = 1'b1;
                end
                default: begin
                    if (st_q.cmd[0] && rem_pos) begin
                        st_d.data = fetched;
                        st_d.ptr  = st_q.ptr + {5'b0, adv};
                        if (rem_last) begin
                            st_d.phase = (stored_cyc[2] && stored_cyc[0]) ? PH_IDLE : PH_WAIT;
                            st_d = st_clear_edid(st_d);
                        end
                    end
                    rdata_d = st_d.data;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= st_reset_value();
            rdata_q <= '0;
        end else begin
            st_q    <= st_d;
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/edid_reg_ctrl_chk.sv
module edid_reg_ctrl_chk
    import edid_ctrl_pkg::*;
#(
    parameter int EDID_BYTES = 128
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        rd_en,
    input logic [1:0]  addr,
    input logic [31:0] wdata,
    input logic        inuse,
    input logic        active,
    input phase_t      phase,
    input logic [7:0]  ptr,
    input logic [31:0] data
);
    localparam logic [8:0] LIMIT = 9'(EDID_BYTES);

    // R2: a status read takes the semaphore
    a_r2_inuse_set: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr == REG_STAT) |=> inuse);

    // R2: writing one to the semaphore bit releases it
    a_r2_inuse_clr: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_STAT && wdata[ST_INUSE]) |=> !inuse);

    // R7: active only rises because of a command write
    a_r7_active_src: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(wr_en && addr == REG_CMD));

    // R9: the wait phase is entered only by a data read
    a_r9_wait_entry: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && $past(phase) != PH_WAIT)
            |-> $past(rd_en && !wr_en && addr == REG_DATA));

    // R8: one data read moves the pointer forward by at most four
    a_r8_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr == REG_DATA)
            |=> (ptr == 8'd0) || ((ptr - $past(ptr)) <= 8'd4));

    // R10: at or beyond the memory end the pointer does not advance
    a_r10_no_adv_end: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr == REG_DATA && {1'b0, ptr} >= LIMIT)
            |=> (ptr == $past(ptr)) || (ptr == 8'd0));

    // R12: data register writes leave the data word alone
    a_r12_data_wr: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_DATA) |=> $stable(data));

endmodule

bind edid_reg_ctrl edid_reg_ctrl_chk #(.EDID_BYTES(EDID_BYTES)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .inuse  (st_q.inuse),
    .active (st_q.active),
    .phase  (st_q.phase),
    .ptr    (st_q.ptr),
    .data   (st_q.data)
);

// File: tb/sim_edid_reg_ctrl.sv
module sim_edid_reg_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NPORT = 4;
    localparam int NB = 128;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [1:0]       addr = 2'd0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic [NPORT-1:0] disp_present = 4'b0111;
    logic [NPORT-1:0] disp_is_dp = 4'b0010;
    logic [NB*8-1:0]  edid_bytes;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_q [$];
    logic [31:0] msk_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    edid_reg_ctrl #(.NPORT(NPORT), .EDID_BYTES(NB)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .disp_present(disp_present),
        .disp_is_dp(disp_is_dp), .edid_bytes(edid_bytes)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] eb(int k);
        return 8'((k * 7 + 3) & 255);
    endfunction

    function automatic logic [31:0] pk(logic [7:0] b0, logic [7:0] b1,
                                       logic [7:0] b2, logic [7:0] b3);
        return {b3, b2, b1, b0};
    endfunction

    function automatic logic [31:0] cmdw(bit clr, logic [2:0] cyc, int total,
                                         int idx, logic [6:0] ta, bit rd);
        return {clr, 1'b0, 2'b00, cyc, 9'(total), 8'(idx), ta, rd};
    endfunction

    // monitor: compare each read result against the scoreboard front
    always @(posedge clk) rd_seen <= rd_en && !wr_en && !rst;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e, m;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual %h expected none", rdata);
            end else begin
                e = exp_q.pop_front();
                m = msk_q.pop_front();
                t = tag_q.pop_front();
                if ((rdata & m) !== (e & m)) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h (mask %h)", t, rdata, e, m);
                end
            end
        end
    end

    task automatic acc(bit w, logic [1:0] a, logic [31:0] d);
        wr_en = w;
        rd_en = !w;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        acc(1'b1, a, d);
    endtask

    task automatic rd(logic [1:0] a, logic [31:0] e, logic [31:0] m, string t);
        exp_q.push_back(e);
        msk_q.push_back(m);
        tag_q.push_back(t);
        acc(1'b0, a, '0);
    endtask

    localparam logic [31:0] ALL = 32'hFFFF_FFFF;
    localparam logic [31:0] NOU = 32'hFFFF_7FFF;
    logic [31:0] w3, c10;

    initial begin
        for (int k = 0; k < NB; k++) edid_bytes[8*k +: 8] = eb(k);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, R2 semaphore and read-only bits
        rd(2, 32'h0000_0C00, ALL, "R1 reset status");
        rd(2, 32'h0000_8C00, ALL, "R2 in-use set by read");
        wr(2, 32'h0000_8000);
        rd(2, 32'h0000_0C00, ALL, "R2 in-use cleared by write");
        wr(2, 32'h0000_7FFF);
        rd(2, 32'h0000_8C00, ALL, "R2 other bits read-only");

        // R3 good port, R4/R5 command readback
        wr(0, 32'hFFFF_FFF9);
        rd(2, 32'h0000_0800, NOU, "R3 non-DP port clears error");
        rd(0, 32'h0000_0001, ALL, "R3 pin select readback");
        wr(1, cmdw(0, 3'd5, 10, 0, 7'h50, 1) | 32'h4000_0000);
        rd(1, cmdw(0, 3'd5, 10, 0, 7'h50, 1), ALL, "R5 software-ready stripped");
        rd(2, 32'h0000_0A00, NOU, "R7 data cycle sets active");

        // R8 packing and partial last word, R9 stop-type end
        rd(3, pk(eb(0), eb(1), eb(2), eb(3)), ALL, "R8 first word");
        rd(3, pk(eb(4), eb(5), eb(6), eb(7)), ALL, "R8 second word");
        w3 = pk(eb(8), eb(9), eb(6), eb(7));
        rd(3, w3, ALL, "R8 partial word keeps old lanes");
        rd(3, w3, ALL, "R9 no bytes left returns old word");
        rd(2, 32'h0000_0A00, NOU, "R9 stop-type ends idle");

        // R8 read direction clear, R12 data write ignored
        wr(0, 32'h1);
        wr(1, cmdw(0, 3'd1, 4, 0, 7'h50, 0));
        wr(3, 32'hDEAD_BEEF);
        rd(3, w3, ALL, "R12 data write and R8 write-direction read");

        // R4 foreign address, R10 unselected fetch, R9 wait end
        wr(0, 32'h1);
        wr(1, cmdw(0, 3'd1, 4, 0, 7'h37, 1));
        rd(3, 32'h0, ALL, "R10 unselected fetch gives zero (R4)");
        rd(2, 32'h0000_4A00, NOU, "R9 no-stop end enters wait");

        // R6 index load
        wr(0, 32'h1);
        wr(1, cmdw(0, 3'd3, 126, 120, 7'h50, 1));
        rd(3, pk(eb(120), eb(121), eb(122), eb(123)), ALL, "R6 index loads pointer");
        rd(3, pk(eb(124), eb(125), eb(122), eb(123)), ALL, "R6 indexed tail");
        rd(2, 32'h0000_4A00, NOU, "R9 indexed no-stop wait");
        wr(0, 32'h1);
        rd(2, 32'h0000_0800, NOU, "R3 pin select leaves wait");

        // R10 past end, R7 effective stop
        wr(1, cmdw(0, 3'd7, 135, 126, 7'h50, 1));
        rd(3, pk(eb(126), eb(127), 8'h0, 8'h0), ALL, "R10 end of memory fill");
        rd(3, 32'h0, ALL, "R10 past end zero");
        wr(1, cmdw(0, 3'd4, 0, 0, 7'h00, 0));
        rd(2, 32'h0000_0800, NOU, "R7 stop after data cycle");

        // R7 stop ignored after no-cycle
        wr(0, 32'h1);
        wr(1, cmdw(0, 3'd0, 8, 0, 7'h50, 1));
        rd(2, 32'h0000_0800, NOU, "R7 no-cycle leaves active clear");
        wr(1, cmdw(0, 3'd4, 8, 0, 7'h50, 1));
        rd(3, pk(eb(0), eb(1), eb(2), eb(3)), ALL, "R7 stop ignored keeps selection");

        // R3 DP port, absent port, invalid select; R10 unavailable
        wr(0, 32'h2);
        rd(2, 32'h0000_0C00, NOU, "R3 DP port sets error");
        wr(1, cmdw(0, 3'd5, 4, 0, 7'h50, 1));
        rd(3, 32'h0, ALL, "R10 unavailable fetch gives zero");
        rd(2, 32'h0000_0E00, NOU, "R9 active kept, idle");
        wr(0, 32'h4);
        rd(2, 32'h0000_0C00, NOU, "R3 absent port sets error");
        wr(0, 32'h1);
        wr(0, 32'h6);
        rd(2, 32'h0000_0800, NOU, "R3 invalid select keeps error");
        rd(0, 32'h0000_0006, ALL, "R3 invalid select stored");

        // R11 clear-interrupt protocol
        wr(0, 32'h1);
        c10 = cmdw(1, 3'd5, 8, 0, 7'h50, 1);
        wr(1, c10);
        rd(2, 32'h0000_0A00, NOU, "R11 armed command active");
        wr(1, cmdw(1, 3'd4, 0, 0, 7'h00, 0));
        rd(2, 32'h0000_0A00, NOU, "R11 write while armed ignored");
        rd(1, c10, ALL, "R11 command unchanged while armed");
        wr(1, 32'h0);
        rd(2, 32'h0000_0800, ALL, "R11 release resets status");
        rd(1, c10 & 32'h7FFF_FFFF, ALL, "R11 release clears bit 31 only");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule